// File: doc/BRIEF.md
# OFDM Frame Airtime Calculator

This block works out how many microseconds a frame occupies the medium when it is sent with OFDM at a given bit rate and channel bandwidth. A request carries the frame length in bytes, the bit rate in units of 100 kb/s and a two-bit bandwidth code, qualified by a one-cycle start strobe. The block adds the interframe gap, the preamble and the time of the whole number of data symbols the payload needs. It reports the result with a one-cycle done strobe.

The symbol count is a ceiling division. The numerator is ten times the bit count. The divisor is the bit rate times the symbol time. A restoring divider resolves one quotient bit per clock. The control is a state machine with six named states:
- `ST_IDLE` waits for a start.
- `ST_PREP` forms the numerator and divisor and loads the divider.
- `ST_DIVIDE` waits for the divider.
- `ST_SCALE` rounds up and assembles the total.
- `ST_FAULT` handles a zero bit rate.
- `ST_REPORT` raises done for one cycle.

The transitions are as follows:
- From `ST_IDLE`, a start goes to `ST_PREP`, or to `ST_FAULT` when the rate is zero.
- `ST_PREP` always goes to `ST_DIVIDE`.
- `ST_DIVIDE` goes to `ST_SCALE` when the divider finishes.
- `ST_SCALE` and `ST_FAULT` both go to `ST_REPORT`.
- `ST_REPORT` returns to `ST_IDLE`.

The divider has its own two states, `DV_IDLE` and `DV_RUN`. A load moves it to `DV_RUN`. The last iteration moves it back to `DV_IDLE`.

Top module: `airtime_calc`

## Requirements
- R1: A completed non-fault request returns dur_o = gap + preamble + symbol_time × symbols, where the three timing values are set by the bandwidth code latched with the request.
- R2: The bit count is 22 + 8 × length. The symbol count is the smallest integer at or above (bit count × 10) / (rate × symbol_time).
- R3: Bandwidth code 0 (normal) uses a 16 µs gap, a 20 µs preamble and a 4 µs symbol.
- R4: Bandwidth code 1 (double width) uses an 8 µs gap, a 10 µs preamble and a 4 µs symbol.
- R5: Bandwidth code 2 (half width) uses a 32 µs gap, a 40 µs preamble and an 8 µs symbol.
- R6: Bandwidth code 3 (quarter width) uses a 64 µs gap, an 80 µs preamble and a 16 µs symbol.
- R7: When the division is exact, no extra symbol is added. Any nonzero remainder adds exactly one symbol.
- R8: For a nonzero rate, done_o is high for exactly one cycle. Counting the rising edge that samples start_i as edge 1, done_o rises on edge NUM_W+4, where NUM_W = LEN_W+8.
- R9: While busy_o is high, start_i is ignored. The running result is not altered and no second done_o follows.
- R10: A zero rate skips the division. Done rises on edge 2, dur_o is all ones and err_o is 1. err_o returns to 0 with the next non-fault result.
- R11: After reset, busy_o, done_o, dur_o and err_o are all zero. dur_o and err_o hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| len_i | input | LEN_W | Frame length in bytes |
| rate_i | input | RATE_W | Bit rate in 100 kb/s units |
| mode_i | input | 2 | Bandwidth code (0 normal, 1 double, 2 half, 3 quarter) |
| busy_o | output | 1 | High from an accepted start until the done cycle, inclusive |
| done_o | output | 1 | One-cycle result strobe |
| dur_o | output | LEN_W+8 | Airtime in microseconds |
| err_o | output | 1 | Zero-rate fault flag |

## Verification
The bench builds the block with its defaults: a 12-bit length and a 10-bit rate, giving a 20-bit dividend and a 20-cycle division. This makes 4095-byte frames at a rate of 1 reachable, so the largest quotient and the widest duration in quarter-width mode are exercised. It also makes exact and inexact divisions at small lengths reachable, along with the full 1023 rate field. The fixed 24-edge latency is checked against the derived dividend width.

// File: rtl/airtime_pkg.sv
package airtime_pkg;

    typedef enum logic [1:0] {
        BW_NORMAL  = 2'd0,
        BW_DOUBLE  = 2'd1,
        BW_HALF    = 2'd2,
        BW_QUARTER = 2'd3
    } bw_mode_e;

    localparam int unsigned CONST_W     = 8;
    localparam int unsigned SHIFT_W     = 3;
    localparam int unsigned HDR_BITS    = 22;
    localparam int unsigned BASE_GAP    = 16;
    localparam int unsigned BASE_PRE    = 20;
    localparam int unsigned BASE_SYMLOG = 2;
    localparam int unsigned DBL_GAP     = 8;
    localparam int unsigned DBL_PRE     = 10;
    localparam int unsigned HALF_GAP    = 32;
    localparam int unsigned QTR_GAP     = 64;

    typedef struct packed {
        logic [CONST_W-1:0] gap;
        logic [CONST_W-1:0] pre;
        logic [SHIFT_W-1:0] sym_log;
    } bw_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PREP   = 3'd1,
        ST_DIVIDE = 3'd2,
        ST_SCALE  = 3'd3,
        ST_FAULT  = 3'd4,
        ST_REPORT = 3'd5
    } calc_state_e;

    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } div_state_e;

endpackage

// File: rtl/airtime_mode_table.sv
module airtime_mode_table
    import airtime_pkg::*;
(
    input  logic [1:0] mode_i,
    output bw_timing_t timing_o
);

    always_comb begin
        timing_o = '0;
        unique case (bw_mode_e'(mode_i))
            BW_NORMAL: begin
                timing_o.gap     = CONST_W'(BASE_GAP);
                timing_o.pre     = CONST_W'(BASE_PRE);
                timing_o.sym_log = SHIFT_W'(BASE_SYMLOG);
            end
            BW_DOUBLE: begin
                timing_o.gap     = CONST_W'(DBL_GAP);
                timing_o.pre     = CONST_W'(DBL_PRE);
                timing_o.sym_log = SHIFT_W'(BASE_SYMLOG);
            end
            BW_HALF: begin
                timing_o.gap     = CONST_W'(HALF_GAP);
                timing_o.pre     = CONST_W'(BASE_PRE * 2);
                timing_o.sym_log = SHIFT_W'(BASE_SYMLOG + 1);
            end
            BW_QUARTER: begin
                timing_o.gap     = CONST_W'(QTR_GAP);
                timing_o.pre     = CONST_W'(BASE_PRE * 4);
                timing_o.sym_log = SHIFT_W'(BASE_SYMLOG + 2);
            end
            default: timing_o = '0;
        endcase
    end

endmodule

// File: rtl/airtime_div.sv
module airtime_div
    import airtime_pkg::*;
#(
    parameter int unsigned NUM_W = 20,
    parameter int unsigned DEN_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quot_o,
    output logic [DEN_W-1:0] rem_o
);

    localparam int unsigned CNT_W  = $clog2(NUM_W + 1);
    localparam int unsigned PROD_W = NUM_W + DEN_W;

    div_state_e         st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_W-1:0]   q_q;
    logic [DEN_W-1:0]   r_q;
    logic [DEN_W-1:0]   den_q;
    logic [NUM_W-1:0]   num_q;
    logic               done_q;

    logic [DEN_W:0]     shifted;
    logic               fits;
    logic [DEN_W:0]     diff;
    logic [DEN_W-1:0]   r_next;

    always_comb begin
        shifted = {r_q, q_q[NUM_W-1]};
        fits    = shifted >= {1'b0, den_q};
        diff    = shifted - {1'b0, den_q};
        r_next  = fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= DV_IDLE;
            cnt_q  <= '0;
            q_q    <= '0;
            r_q    <= '0;
            den_q  <= '0;
            num_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                DV_IDLE: begin
                    if (load_i) begin
                        q_q   <= num_i;
                        num_q <= num_i;
                        den_q <= den_i;
                        r_q   <= '0;
                        cnt_q <= CNT_W'(NUM_W);
                        st_q  <= DV_RUN;
                    end
                end
                DV_RUN: begin
                    r_q   <= r_next;
                    q_q   <= {q_q[NUM_W-2:0], fits};
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) begin
                        done_q <= 1'b1;
                        st_q   <= DV_IDLE;
                    end
                end
                default: st_q <= DV_IDLE;
            endcase
        end
    end

    assign done_o = done_q;
    assign quot_o = q_q;
    assign rem_o  = r_q;

    assert_rem_below_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < den_q));

    assert_quotient_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((PROD_W'(quot_o) * PROD_W'(den_q) + PROD_W'(rem_o)) == PROD_W'(num_q)));

endmodule

// File: rtl/airtime_calc.sv
module airtime_calc
    import airtime_pkg::*;
#(
    parameter int unsigned LEN_W  = 12,
    parameter int unsigned RATE_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [LEN_W-1:0]     len_i,
    input  logic [RATE_W-1:0]    rate_i,
    input  logic [1:0]           mode_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [LEN_W+7:0]     dur_o,
    output logic                 err_o
);

    localparam int unsigned NUM_W   = LEN_W + 8;
    localparam int unsigned DEN_W   = RATE_W + 5;
    localparam int unsigned DUR_W   = NUM_W;

    calc_state_e          state_q, state_n;
    logic [LEN_W-1:0]     len_q;
    logic [RATE_W-1:0]    rate_q;
    logic [1:0]           mode_q;
    logic [DUR_W-1:0]     dur_q;
    logic                 err_q;

    bw_timing_t           timing;
    logic [NUM_W-1:0]     bits_c;
    logic [NUM_W-1:0]     num_c;
    logic [DEN_W-1:0]     den_c;
    logic                 div_done;
    logic [NUM_W-1:0]     div_quot;
    logic [DEN_W-1:0]     div_rem;
    logic [NUM_W-1:0]     symbols_c;
    logic [DUR_W-1:0]     airtime_c;
    logic [DUR_W-1:0]     floor_c;

    airtime_mode_table u_table (
        .mode_i   (mode_q),
        .timing_o (timing)
    );

    always_comb begin
        bits_c    = NUM_W'(HDR_BITS) + (NUM_W'(len_q) << 3);
        num_c     = (bits_c << 3) + (bits_c << 1);
        den_c     = DEN_W'(rate_q) << timing.sym_log;
        symbols_c = div_quot + NUM_W'(div_rem != '0);
        airtime_c = DUR_W'(timing.gap) + DUR_W'(timing.pre)
                  + (DUR_W'(symbols_c) << timing.sym_log);
        floor_c   = DUR_W'(timing.gap) + DUR_W'(timing.pre)
                  + (DUR_W'(1) << timing.sym_log);
    end

    airtime_div #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (state_q == ST_PREP),
        .num_i  (num_c),
        .den_i  (den_c),
        .done_o (div_done),
        .quot_o (div_quot),
        .rem_o  (div_rem)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_n = (rate_i == '0) ? ST_FAULT : ST_PREP;
            end
            ST_PREP:   state_n = ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_n = ST_SCALE;
            ST_SCALE:  state_n = ST_REPORT;
            ST_FAULT:  state_n = ST_REPORT;
            ST_REPORT: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // request latch and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            rate_q <= '0;
            mode_q <= '0;
            dur_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        len_q  <= len_i;
                        rate_q <= rate_i;
                        mode_q <= mode_i;
                    end
                end
                ST_SCALE: begin
                    dur_q <= airtime_c;
                    err_q <= 1'b0;
                end
                ST_FAULT: begin
                    dur_q <= '1;
                    err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_REPORT);
    assign dur_o  = dur_q;
    assign err_o  = err_q;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_holds_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ($stable(len_q) && $stable(rate_q) && $stable(mode_q)));

    assert_fault_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (dur_o == '1));

    assert_good_needs_rate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (rate_q != '0));

    assert_at_least_one_symbol_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (dur_o >= floor_c));

endmodule

// File: tb/test_airtime_calc.sv
module test_airtime_calc;

    localparam int LEN_W  = 12;
    localparam int RATE_W = 10;
    localparam int NUM_W  = LEN_W + 8;
    localparam int NVEC   = 12;

    localparam int VLEN [NVEC] = '{0, 0, 14, 1500, 1500, 100, 100, 4095, 4095, 10, 1, 255};
    localparam int VRATE[NVEC] = '{55, 54, 60, 540, 270, 30, 15, 1, 1023, 120, 1, 480};
    localparam int VMODE[NVEC] = '{0, 0, 0, 0, 1, 2, 3, 3, 0, 2, 1, 3};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LEN_W-1:0]  len_i = '0;
    logic [RATE_W-1:0] rate_i = '0;
    logic [1:0]        mode_i = '0;
    logic              busy_o, done_o, err_o;
    logic [NUM_W-1:0]  dur_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    airtime_calc #(.LEN_W(LEN_W), .RATE_W(RATE_W)) i_airtime_calc (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .rate_i(rate_i), .mode_i(mode_i), .busy_o(busy_o), .done_o(done_o),
        .dur_o(dur_o), .err_o(err_o)
    );

    function automatic int expect_air(int len, int rate, int mode);
        int gap, pre, sym, num, den, syms;
        case (mode)
            0: begin gap = 16; pre = 20; sym = 4;  end
            1: begin gap = 8;  pre = 10; sym = 4;  end
            2: begin gap = 32; pre = 40; sym = 8;  end
            default: begin gap = 64; pre = 80; sym = 16; end
        endcase
        num  = (22 + 8 * len) * 10;
        den  = rate * sym;
        syms = (num + den - 1) / den;
        return gap + pre + sym * syms;
    endfunction

    task automatic check(string req, int actual, int expected);
        total++;
        if (actual != expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Issue a request and wait for done; returns the edge count at which done was seen.
    task automatic run_op(int len, int rate, int mode, output int edges);
        @(negedge clk);
        len_i = LEN_W'(len); rate_i = RATE_W'(rate); mode_i = 2'(mode);
        start_i = 1'b1;
        @(posedge clk);
        edges = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (done_o !== 1'b1 && edges < 200) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int edges;
        int exp_a;
        int extra_done;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 busy", int'(busy_o), 0);
        check("R11 done", int'(done_o), 0);
        check("R11 dur",  int'(dur_o), 0);
        check("R11 err",  int'(err_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1..R7 across bandwidth codes, exact and inexact divisions; R8 latency
        for (int v = 0; v < NVEC; v++) begin
            run_op(VLEN[v], VRATE[v], VMODE[v], edges);
            check($sformatf("R1/R2 vec%0d mode%0d (R3 R4 R5 R6 R7)", v, VMODE[v]),
                  int'(dur_o), expect_air(VLEN[v], VRATE[v], VMODE[v]));
            check($sformatf("R10 err vec%0d", v), int'(err_o), 0);
            check($sformatf("R8 latency vec%0d", v), edges, NUM_W + 4);
            @(negedge clk);
            check($sformatf("R8 pulse vec%0d", v), int'(done_o), 0);
            check($sformatf("R11 hold vec%0d", v), int'(dur_o),
                  expect_air(VLEN[v], VRATE[v], VMODE[v]));
        end

        // R7: exact division 220/220 -> 1 symbol, 40 us; 220/216 -> 2 symbols, 44 us
        run_op(0, 55, 0, edges);
        check("R7 exact", int'(dur_o), 40);
        run_op(0, 54, 0, edges);
        check("R7 round-up", int'(dur_o), 44);

        // R9: start while busy is ignored
        exp_a = expect_air(100, 60, 0);
        @(negedge clk);
        len_i = 12'd100; rate_i = 10'd60; mode_i = 2'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        len_i = 12'd5; rate_i = 10'd10; mode_i = 2'd3; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (done_o !== 1'b1) @(negedge clk);
        check("R9 result unchanged", int'(dur_o), exp_a);
        extra_done = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (done_o) extra_done++;
        end
        check("R9 no second done", extra_done, 0);
        check("R9 idle after", int'(busy_o), 0);

        // R10: zero rate
        run_op(20, 0, 2, edges);
        check("R10 saturated", int'(dur_o), (1 << NUM_W) - 1);
        check("R10 err set", int'(err_o), 1);
        check("R10 latency", edges, 2);
        @(negedge clk);
        check("R10 pulse", int'(done_o), 0);
        check("R10 err held", int'(err_o), 1);
        run_op(20, 60, 2, edges);
        check("R10 err cleared", int'(err_o), 0);
        check("R5 after fault", int'(dur_o), expect_air(20, 60, 2));

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule